// File: doc/BRIEF.md
# Receive-Line Glitch Integrator

This block sits between an asynchronous serial receive pin and a bus protocol receiver and removes short noise from the line. The raw pin first passes through a multi-flop synchronizer. The synchronized level then steers a saturating up/down integrator. A high sample moves the count toward full scale and a low sample moves it toward zero. The filtered level is held in an output latch with hysteresis. The latch goes high only when the count reaches full scale and goes low only when the count reaches zero. At every count in between, the latch keeps its value.

A level therefore has to persist for as many samples as the count span before it appears at the output. Anything shorter is absorbed. With the default parameters the integrator needs 15 samples and the synchronizer adds two flops. An input edge therefore shows up on the seventeenth rising clock edge after the first edge that samples the new level. Measured from the asynchronous input change itself, this is 16 to 17 clock periods. A one-cycle strobe marks each change of the filtered level, so that a downstream receiver can timestamp transitions.

Top module: `rx_glitch_integrator`

## Requirements
- R1: While `rst` is high at a clock edge, the block takes its idle state. With `IDLE_HIGH`=1 (the default), the count goes to full scale (15), `rx_filt` goes to 1 and `rx_edge` goes to 0.
- R2: The count saturates at both ends. A high sample at 15 leaves it at 15, and a low sample at 0 leaves it at 0. After the line has been held high for any length of time, a falling edge still takes exactly the nominal delay of R3.
- R3: If `rx_raw` falls and then stays low, `rx_filt` becomes 0 at the 17th rising edge after the first edge that samples the low level. This is 2 synchronizer flops plus 15 integration steps.
- R4: If `rx_raw` rises and then stays high, `rx_filt` becomes 1 at the 17th rising edge after the first edge that samples the high level.
- R5: A pulse of the opposite level that lasts 1 to 14 clock cycles never changes `rx_filt` and never raises `rx_edge`.
- R6: A pulse of the opposite level that lasts exactly 15 cycles does change `rx_filt`.
- R7: Inside the integrator, the count rises by one for each high sample below 15 and falls by one for each low sample above 0. `rx_filt` goes to 1 only when the count reaches 15, goes to 0 only when it reaches 0, and otherwise holds.
- R8: `rx_edge` is high for exactly the one cycle in which `rx_filt` shows a new value, and it is low in every other cycle.
- R9: Suppose a transition is followed by a noise burst of B cycles and then a steady new level. Then `rx_filt` settles at the new level, and its last change comes no later than B+17 rising edges after the burst begins.
- R10: With `IDLE_HIGH`=0, reset clears the count to 0 and sets `rx_filt` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_raw | input | 1 | Raw asynchronous receive line |
| rx_filt | output | 1 | Filtered receive level |
| rx_edge | output | 1 | One-cycle strobe on each change of `rx_filt` |

## Verification
The bench targets the boundary between rejected and accepted pulses. It drives pulses of 14 and 15 cycles. A design that counted one step too few would let the 14-cycle pulse through, and one that counted one step too many would swallow the 15-cycle pulse. It measures edge latency in both directions after long idle periods. A counter that wrapped instead of saturating would then toggle early or show the wrong delay. A latch that followed the count midpoint instead of holding between the end points would chatter under the random run-length stimulus. The bench also sends noise bursts right after a transition, where a design with a faulty hold or step would settle late or at the wrong level, and it watches for a strobe that is missing or lasts two cycles.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   // direction of one integrator step
   typedef enum logic [1:0] {
      STEP_UP   = 2'd0,
      STEP_DOWN = 2'd1,
      STEP_PARK = 2'd2
   } step_e;

   // command applied to the output level latch
   typedef enum logic [1:0] {
      LVL_HOLD = 2'd0,
      LVL_SET  = 2'd1,
      LVL_CLR  = 2'd2
   } lvl_cmd_e;

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rxf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d_async};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rxf_integ.sv
module rxf_integ
   import rxf_pkg::*;
#(
   parameter int   CNT_W    = 4,
   parameter logic RST_FULL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample,
   output logic [CNT_W-1:0] cnt_nxt
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("rxf_integ: CNT_W must lie in 2..16");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_RST  = RST_FULL ? CNT_MAX : CNT_ZERO;

   logic [CNT_W-1:0] cnt_q;
   step_e            step;

   always_comb begin
      if (sample) step = (cnt_q == CNT_MAX)  ? STEP_PARK : STEP_UP;
      else        step = (cnt_q == CNT_ZERO) ? STEP_PARK : STEP_DOWN;
   end

   always_comb begin
      case (step)
         STEP_UP:   cnt_nxt = cnt_q + 1'b1;
         STEP_DOWN: cnt_nxt = cnt_q - 1'b1;
         default:   cnt_nxt = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= CNT_RST;
      else     cnt_q <= cnt_nxt;
   end

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
      (sample && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

   p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
      (!sample && cnt_q == CNT_ZERO) |=> cnt_q == CNT_ZERO);

   p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
      (sample && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

   p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
      (!sample && cnt_q != CNT_ZERO) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rxf_latch.sv
module rxf_latch
   import rxf_pkg::*;
#(
   parameter int   CNT_W   = 4,
   parameter logic RST_LVL = 1'b1,
   parameter bit   STB_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_nxt,
   output logic             lvl,
   output logic             stb
);

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   lvl_cmd_e cmd;
   logic     lvl_d;

   always_comb begin
      if      (cnt_nxt == CNT_MAX)  cmd = LVL_SET;
      else if (cnt_nxt == CNT_ZERO) cmd = LVL_CLR;
      else                          cmd = LVL_HOLD;
   end

   always_comb begin
      case (cmd)
         LVL_SET: lvl_d = 1'b1;
         LVL_CLR: lvl_d = 1'b0;
         default: lvl_d = lvl;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) lvl <= RST_LVL;
      else     lvl <= lvl_d;
   end

   generate
      if (STB_EN) begin : g_stb
         logic stb_q;
         always_ff @(posedge clk) begin
            if (rst) stb_q <= 1'b0;
            else     stb_q <= (lvl_d != lvl);
         end
         assign stb = stb_q;

         p_stb_on_change_r8: assert property (@(posedge clk) disable iff (rst)
            (lvl != $past(lvl)) |-> stb);
         p_stb_only_change_r8: assert property (@(posedge clk) disable iff (rst)
            stb |-> (lvl != $past(lvl)));
      end else begin : g_no_stb
         assign stb = 1'b0;
      end
   endgenerate

   p_set_at_full_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt_nxt == CNT_MAX) |=> lvl);

   p_clr_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (cnt_nxt == CNT_ZERO) |=> !lvl);

   p_hold_mid_r7: assert property (@(posedge clk) disable iff (rst)
      (cnt_nxt != CNT_ZERO && cnt_nxt != CNT_MAX) |=> $stable(lvl));

endmodule

// File: rtl/rx_glitch_integrator.sv
module rx_glitch_integrator #(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_HIGH   = 1'b1,
   parameter bit EDGE_STB_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic rx_raw,
   output logic rx_filt,
   output logic rx_edge
);

   localparam logic IDLE_LVL = IDLE_HIGH ? 1'b1 : 1'b0;

   logic             rx_sync;
   logic [CNT_W-1:0] cnt_nxt;

   rxf_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_LVL)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (rx_raw),
      .q       (rx_sync)
   );

   rxf_integ #(
      .CNT_W    (CNT_W),
      .RST_FULL (IDLE_LVL)
   ) u_integ (
      .clk     (clk),
      .rst     (rst),
      .sample  (rx_sync),
      .cnt_nxt (cnt_nxt)
   );

   rxf_latch #(
      .CNT_W   (CNT_W),
      .RST_LVL (IDLE_LVL),
      .STB_EN  (EDGE_STB_EN)
   ) u_latch (
      .clk     (clk),
      .rst     (rst),
      .cnt_nxt (cnt_nxt),
      .lvl     (rx_filt),
      .stb     (rx_edge)
   );

   p_reset_level_r1: assert property (@(posedge clk)
      $past(rst) |-> (rx_filt == IDLE_LVL && !rx_edge));

endmodule

// File: tb/rx_glitch_integrator_bench.sv
`timescale 1ns/1ps
module rx_glitch_integrator_bench;

   localparam int NOM_DLY = 17;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rx  = 1'b1;
   logic rx_filt, rx_edge, lo_filt, lo_edge;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   rx_glitch_integrator u_rx_glitch_integrator (
      .clk(clk), .rst(rst), .rx_raw(rx), .rx_filt(rx_filt), .rx_edge(rx_edge));

   rx_glitch_integrator #(.IDLE_HIGH(1'b0)) u_rx_glitch_integrator_lo (
      .clk(clk), .rst(rst), .rx_raw(rx), .rx_filt(lo_filt), .rx_edge(lo_edge));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model from the requirements
   logic m1, m2, mo, ms;
   int   mc;
   function automatic int next_cnt(input int c, input logic s);
      if (s) return (c == 15) ? 15 : c + 1;
      return (c == 0) ? 0 : c - 1;
   endfunction
   function automatic logic next_lvl(input int c, input logic o);
      if (c == 15) return 1'b1;
      if (c == 0)  return 1'b0;
      return o;
   endfunction

   always @(posedge clk) begin : model
      int   nc;
      logic no;
      if (rst) begin
         m1 <= 1'b1; m2 <= 1'b1; mc <= 15; mo <= 1'b1; ms <= 1'b0;
      end else begin
         nc = next_cnt(mc, m2);
         no = next_lvl(nc, mo);
         m1 <= rx; m2 <= m1; mc <= nc; mo <= no; ms <= (no != mo);
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R7 filtered level vs model", rx_filt, mo);
         chk("R8 edge strobe vs model", rx_edge, ms);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input logic tgt, input int maxw, output int n, output logic stb);
      n = 0; stb = 1'b0;
      while (n < maxw) begin
         @(negedge clk);
         n++;
         if (rx_filt == tgt) begin stb = rx_edge; break; end
      end
   endtask

   initial begin : watchdog
      #(20 * 190000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin : main
      int   n;
      logic s;
      bit   bad;
      void'($urandom(32'd2024));
      rx = 1'b1; rst = 1'b1;
      cyc(3);
      chk("R1 reset filtered level", rx_filt, 1);
      chk("R1 reset edge strobe", rx_edge, 0);
      chk("R10 low-idle reset level", lo_filt, 0);
      rst = 1'b0;
      cyc(60);

      // R2 / R3: long high hold then clean fall
      rx = 1'b0;
      measure(1'b0, 40, n, s);
      chk("R2 R3 fall delay edges", n, NOM_DLY);
      chk("R8 strobe at fall", s, 1);
      cyc(30);

      // R4: clean rise
      rx = 1'b1;
      measure(1'b1, 40, n, s);
      chk("R4 rise delay edges", n, NOM_DLY);
      chk("R8 strobe at rise", s, 1);
      cyc(30);

      // R5: short low pulses on a high line
      for (int w = 1; w <= 14; w++) begin
         bad = 1'b0;
         rx = 1'b0; cyc(w); rx = 1'b1;
         for (int k = 0; k < w + 25; k++) begin
            @(negedge clk);
            if (rx_filt !== 1'b1 || rx_edge !== 1'b0) bad = 1'b1;
         end
         chk($sformatf("R5 low pulse %0d rejected", w), bad, 0);
      end

      // R6: 15-cycle pulse is accepted
      rx = 1'b0; cyc(15); rx = 1'b1;
      measure(1'b0, 10, n, s);
      chk("R6 15-cycle low pulse accepted", rx_filt, 0);
      cyc(40);

      // R5 on a low line
      rx = 1'b0; cyc(40);
      for (int w = 1; w <= 14; w += 13) begin
         bad = 1'b0;
         rx = 1'b1; cyc(w); rx = 1'b0;
         for (int k = 0; k < w + 25; k++) begin
            @(negedge clk);
            if (rx_filt !== 1'b0 || rx_edge !== 1'b0) bad = 1'b1;
         end
         chk($sformatf("R5 high pulse %0d rejected", w), bad, 0);
      end

      // R7: random run lengths compared against the model
      for (int i = 0; i < 300; i++) begin
         rx = ~rx;
         cyc($urandom_range(1, 20));
      end
      rx = 1'b1; cyc(40);

      // R9: noisy bursts after a transition
      for (int b = 0; b < 8; b++) begin
         int   blen, last;
         logic tgt, prev;
         tgt  = (b % 2 == 0) ? 1'b0 : 1'b1;
         blen = $urandom_range(4, 30);
         prev = rx_filt; last = 0;
         for (int k = 1; k <= blen + NOM_DLY + 10; k++) begin
            rx = (k <= blen) ? logic'($urandom_range(0, 1)) : tgt;
            @(negedge clk);
            if (rx_filt != prev) begin last = k; prev = rx_filt; end
         end
         chk("R9 burst settles to new level", rx_filt, tgt);
         chk("R9 last change within burst+17", (last <= blen + NOM_DLY) ? 1 : 0, 1);
         cyc(20);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule